// File: doc/BRIEF.md
# High-Voltage Parallel Flash Page Programmer

This block is the host side of a high-voltage parallel programming link. After a start pulse it brings the target into programming mode. It does this in three steps: it switches on the target supply, then lifts the target reset to the supply level, then moves the reset to the high programming voltage. Each step is held for a minimum time. The hold times are derived from the clock frequency parameter and rounded up.

Once in programming mode, the block loads the flash write command a single time. It then takes 16-bit words from a valid/ready stream. Word N of the stream goes to flash word address N. Each word is presented to the target as three byte loads:

- the address low byte,
- the data low byte,
- the data high byte.

The target latches each load on a one-cycle strobe, with the select lines and data bus held steady for the cycle before it. At the end of each page, the block reloads the address high byte only if the 256-word window has changed since the last load. It then pulses the write line and waits for the target to report ready.

When erased-data skipping is enabled, words equal to 0xFFFF produce no loads. A page in which every word was skipped gets no write pulse. After the final page the block loads the no-operation command and drops reset and supply. If the ready line stays low too long after a write, the block powers the target down and flags an error.

Top module: `hv_page_writer`

## Requirements
- R1: While reset is held, and in the idle state with no start pulse, vcc_en, rst_lv_en and rst_hv_en are low, wr_n is high, and xtal1, s_ready, done and err are low.
- R2: Entry timing:
  - vcc_en is high for at least ceil(60 us × CLK_HZ) cycles before rst_lv_en rises.
  - rst_lv_en is high for at least ceil(20 us × CLK_HZ) cycles before rst_hv_en rises, and the two are never high together.
  - The first xtal1 strobe comes at least ceil(10 us × CLK_HZ) cycles after rst_hv_en rises.
  - The whole entry, from the rise of vcc_en to the first strobe, takes less than 64 ms of cycles.
- R3: The first load after entry is the write command: xa=10, bs1=0, pdata=0x10. It is loaded exactly once per run.
- R4: Every written word N produces three loads, in this order:
  - address low: xa=00, bs1=0, pdata=N[7:0];
  - data low: xa=01, bs1=0, pdata=word[7:0];
  - data high: xa=01, bs1=1, pdata=word[15:8].

  Each strobe is high for one cycle, and xa, bs1 and pdata are unchanged from the cycle before it.
- R5: After the last word of a page (the word offset within the page is all ones) or the stream's last word, wr_n goes low for exactly one cycle with bs1=0. No strobe and no write is issued until rdy_bsy has returned high.
- R6: Before a write, the address high byte is loaded (xa=00, bs1=1, pdata=N[15:8]) only when no high byte has yet been loaded in the run, or when it differs from the last one loaded.
- R7: With skip_erased=1, a word equal to 0xFFFF produces no loads. With skip_erased=0, it is written like any other word.
- R8: A page whose words were all skipped produces no address-high load and no write pulse.
- R9: After the final page, the no-operation command (xa=10, bs1=0, pdata=0x00) is loaded. Then vcc_en, rst_lv_en and rst_hv_en go low and done goes high and stays high.
- R10: If rdy_bsy stays low for TMO_CYC cycles of waiting after a write, err goes high and stays high. All supplies go low, and no further strobe, write or s_ready follows.
- R11: A word is taken only when s_valid and s_ready are both high. s_ready is high only while the high voltage is applied and no load or write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begins entry and programming |
| skip_erased | input | 1 | Enables skipping of 0xFFFF words |
| s_valid | input | 1 | Word stream valid |
| s_data | input | 16 | Word stream data |
| s_last | input | 1 | Marks the final word of the image |
| s_ready | output | 1 | Word stream ready |
| rdy_bsy | input | 1 | Target ready (high) / busy (low) |
| vcc_en | output | 1 | Target supply enable |
| rst_lv_en | output | 1 | Drives target reset to the supply level |
| rst_hv_en | output | 1 | Drives target reset to the programming voltage |
| xa | output | 2 | Load type select: 00 address, 01 data, 10 command |
| bs1 | output | 1 | Byte select: 0 low, 1 high |
| pdata | output | 8 | Target data bus |
| xtal1 | output | 1 | Load strobe, one cycle high |
| wr_n | output | 1 | Write pulse, active low |
| done | output | 1 | Programming finished |
| err | output | 1 | Ready timeout abort |

## Verification
Two decisions can land on the same word.

- End of page on a skipped word. The last word of a page may itself be a skipped 0xFFFF while earlier words of that page were written. The page must still be committed.
- Window crossing with an empty page. The page that crosses into a new 256-word window may have been entirely skipped. The next written page must then still reload the high byte.

A 300-word image with random erased words and a fully erased page provokes both cases. Target busy times are random. Every strobe and write the design issues is logged and compared, in order, against a list computed from the image.

// File: rtl/hv_page_writer.sv
module hv_page_writer #(
  parameter int unsigned CLK_HZ     = 8_000_000,
  parameter int unsigned PAGE_WORDS = 16,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned TMO_CYC    = 400_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        skip_erased,
  input  logic        s_valid,
  input  logic [15:0] s_data,
  input  logic        s_last,
  output logic        s_ready,
  input  logic        rdy_bsy,
  output logic        vcc_en,
  output logic        rst_lv_en,
  output logic        rst_hv_en,
  output logic [1:0]  xa,
  output logic        bs1,
  output logic [7:0]  pdata,
  output logic        xtal1,
  output logic        wr_n,
  output logic        done,
  output logic        err
);
  localparam int unsigned PG_W = $clog2(PAGE_WORDS);
  localparam int unsigned T_PWR = int'((64'd60 * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000);
  localparam int unsigned T_RLV = int'((64'd20 * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000);
  localparam int unsigned T_RHV = int'((64'd10 * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000);

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_RLV, S_RHV, S_CMD, S_WORD, S_AL, S_DL, S_DH,
    S_DECIDE, S_AH, S_WRP, S_BSYG, S_BSYW, S_NEXT, S_NOP, S_DONE, S_ERR
  } st_t;

  st_t               st;
  logic [31:0]       cnt;
  logic              ph;
  logic [ADDR_W-1:0] waddr;
  logic [15:0]       wdat;
  logic              last_q;
  logic              dirty;
  logic              hi_vld;
  logic [7:0]        hi_q;

  logic [15:0] waddr16;
  logic        is_ld;
  logic        eop;
  assign waddr16 = 16'(waddr);
  assign eop     = (&waddr[PG_W-1:0]) || last_q;
  assign is_ld   = (st == S_CMD) || (st == S_AL) || (st == S_DL) ||
                   (st == S_DH)  || (st == S_AH) || (st == S_NOP);

  assign vcc_en    = !(st == S_IDLE || st == S_DONE || st == S_ERR);
  assign rst_lv_en = (st == S_RLV);
  assign rst_hv_en = vcc_en && st != S_PWR && st != S_RLV;
  assign xtal1     = is_ld && ph;
  assign wr_n      = (st != S_WRP);
  assign s_ready   = (st == S_WORD);
  assign done      = (st == S_DONE);
  assign err       = (st == S_ERR);

  always_comb begin
    xa = 2'b00; bs1 = 1'b0; pdata = 8'h00;
    case (st)
      S_CMD: begin xa = 2'b10; pdata = 8'h10; end
      S_NOP: begin xa = 2'b10; pdata = 8'h00; end
      S_AL:  pdata = waddr16[7:0];
      S_AH:  begin bs1 = 1'b1; pdata = waddr16[15:8]; end
      S_DL:  begin xa = 2'b01; pdata = wdat[7:0]; end
      S_DH:  begin xa = 2'b01; bs1 = 1'b1; pdata = wdat[15:8]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= 1'b0; waddr <= '0; wdat <= '0;
      last_q <= 1'b0; dirty <= 1'b0; hi_vld <= 1'b0; hi_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin st <= S_PWR; cnt <= '0; end
        S_PWR:
          if (cnt == T_PWR - 1) begin st <= S_RLV; cnt <= '0; end
          else cnt <= cnt + 1;
        S_RLV:
          if (cnt == T_RLV - 1) begin st <= S_RHV; cnt <= '0; end
          else cnt <= cnt + 1;
        S_RHV:
          if (cnt == T_RHV - 1) begin
            st <= S_CMD; cnt <= '0; ph <= 1'b0;
            waddr <= '0; dirty <= 1'b0; hi_vld <= 1'b0;
          end else cnt <= cnt + 1;
        S_CMD, S_AL, S_DL, S_DH, S_AH, S_NOP:
          if (!ph) ph <= 1'b1;
          else begin
            ph <= 1'b0;
            case (st)
              S_CMD: st <= S_WORD;
              S_AL:  st <= S_DL;
              S_DL:  st <= S_DH;
              S_DH:  begin st <= S_DECIDE; dirty <= 1'b1; end
              S_AH:  begin st <= S_WRP; hi_vld <= 1'b1; hi_q <= waddr16[15:8]; end
              default: st <= S_DONE;
            endcase
          end
        S_WORD:
          if (s_valid) begin
            wdat   <= s_data;
            last_q <= s_last;
            st     <= (skip_erased && s_data == 16'hFFFF) ? S_DECIDE : S_AL;
          end
        S_DECIDE:
          if (eop && dirty)
            st <= (hi_vld && hi_q == waddr16[15:8]) ? S_WRP : S_AH;
          else st <= S_NEXT;
        S_WRP:  begin st <= S_BSYG; cnt <= '0; end
        S_BSYG: st <= S_BSYW;
        S_BSYW:
          if (rdy_bsy) begin dirty <= 1'b0; st <= S_NEXT; end
          else if (cnt == TMO_CYC - 1) st <= S_ERR;
          else cnt <= cnt + 1;
        S_NEXT: begin
          waddr <= waddr + 1'b1;
          st    <= last_q ? S_NOP : S_WORD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hv_page_writer_chk.sv
module hv_page_writer_chk #(
  parameter int unsigned CLK_HZ = 8_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_en,
  input logic       rst_lv_en,
  input logic       rst_hv_en,
  input logic [1:0] xa,
  input logic       bs1,
  input logic [7:0] pdata,
  input logic       xtal1,
  input logic       wr_n,
  input logic       s_ready,
  input logic       done,
  input logic       err
);
  localparam int unsigned MIN_PWR = int'((64'd60 * 64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000);

  logic [31:0] vcc_cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcc_cyc <= '0;
    else if (!vcc_en) vcc_cyc <= '0;
    else if (vcc_cyc != 32'hFFFF_FFFF) vcc_cyc <= vcc_cyc + 1;
  end

  a_r1_hv_under_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_hv_en || rst_lv_en) |-> vcc_en);
  a_r2_vcc_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_lv_en) |-> vcc_cyc >= MIN_PWR);
  a_r2_lv_before_hv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_hv_en) |-> $past(rst_lv_en));
  a_r4_strobe_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal1) |-> ($stable(pdata) && $stable(xa) && $stable(bs1)));
  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    xtal1 |=> !xtal1);
  a_r5_wr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!bs1 && rst_hv_en && !xtal1));
  a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> wr_n);
  a_r11_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (rst_hv_en && wr_n && !xtal1));
  a_r9_done_off: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!vcc_en && !rst_hv_en && !s_ready));
  a_r10_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!vcc_en && !s_ready && wr_n && !xtal1));
endmodule

bind hv_page_writer hv_page_writer_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_en(vcc_en), .rst_lv_en(rst_lv_en),
  .rst_hv_en(rst_hv_en), .xa(xa), .bs1(bs1), .pdata(pdata), .xtal1(xtal1),
  .wr_n(wr_n), .s_ready(s_ready), .done(done), .err(err)
);

// File: tb/hv_page_writer_bench.sv
module hv_page_writer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 3_000_000;
  localparam int T60 = 180, T20 = 60, T10 = 30, MS64 = 192_000;
  localparam int TMO = 200;

  logic clk = 0, rst_n = 0, start = 0, skip_erased = 0;
  logic s_valid = 0, s_last = 0, rdy_bsy;
  logic [15:0] s_data = '0;
  logic s_ready, vcc_en, rst_lv_en, rst_hv_en, bs1, xtal1, wr_n, done, err;
  logic [1:0] xa;
  logic [7:0] pdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  hv_page_writer #(.CLK_HZ(CLK_HZ), .PAGE_WORDS(16), .ADDR_W(10), .TMO_CYC(TMO))
  u_hv_page_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_erased(skip_erased),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .rdy_bsy(rdy_bsy), .vcc_en(vcc_en), .rst_lv_en(rst_lv_en), .rst_hv_en(rst_hv_en),
    .xa(xa), .bs1(bs1), .pdata(pdata), .xtal1(xtal1), .wr_n(wr_n),
    .done(done), .err(err));

  int total = 0, bad = 0;
  logic [15:0] img [0:511];
  logic [11:0] exp_ev [0:4095];
  logic [11:0] got_ev [0:4095];
  int n_exp, n_got;
  bit lat_inf = 0;

  int cyc = 0, t_vcc, t_lv, t_hv, t_str;
  int setup_bad, busy_viol, rdy_viol, ovl, post_err, bcnt;
  logic p_xt, p_wr, p_vcc, p_lv, p_hv, p_bs;
  logic [1:0] p_xa;
  logic [7:0] p_d;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      rdy_bsy = 1; n_got = 0; t_vcc = 0; t_lv = 0; t_hv = 0; t_str = 0;
      setup_bad = 0; busy_viol = 0; rdy_viol = 0; ovl = 0; post_err = 0; bcnt = 0;
      p_xt = 0; p_wr = 1; p_vcc = 0; p_lv = 0; p_hv = 0; p_bs = 0; p_xa = 0; p_d = 0;
    end else begin
      if (vcc_en && !p_vcc) t_vcc = cyc;
      if (rst_lv_en && !p_lv) t_lv = cyc;
      if (rst_hv_en && !p_hv) t_hv = cyc;
      if (rst_lv_en && rst_hv_en) ovl++;
      if (s_ready && (!rst_hv_en || !rdy_bsy)) rdy_viol++;
      if (err && (xtal1 || !wr_n || s_ready)) post_err++;
      if (xtal1 && !p_xt) begin
        if (t_str == 0) t_str = cyc;
        if ({xa, bs1, pdata} != {p_xa, p_bs, p_d}) setup_bad++;
        if (!rdy_bsy) busy_viol++;
        if (n_got < 4096) got_ev[n_got] = {1'b0, xa, bs1, pdata};
        n_got++;
      end
      if (!wr_n && p_wr) begin
        if (!rdy_bsy) busy_viol++;
        if (n_got < 4096) got_ev[n_got] = {1'b1, xa, bs1, pdata};
        n_got++;
        rdy_bsy = 0;
        bcnt = lat_inf ? 1_000_000 : int'($urandom_range(20, 1));
      end else if (!rdy_bsy) begin
        if (bcnt == 0) rdy_bsy = 1; else bcnt--;
      end
      p_xt = xtal1; p_wr = wr_n; p_vcc = vcc_en; p_lv = rst_lv_en; p_hv = rst_hv_en;
      p_bs = bs1; p_xa = xa; p_d = pdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input logic [11:0] e);
    if (e[11]) return "R5";
    if (e[10:9] == 2'b10) return (e[7:0] == 8'h10) ? "R3" : "R9";
    if (e[10:9] == 2'b00 && e[8]) return "R6";
    return "R4";
  endfunction

  task automatic gen_exp(input int n, input bit skip, input bit with_nop);
    bit hv = 0, dirty = 0;
    logic [7:0] hi = 0;
    n_exp = 0;
    exp_ev[n_exp++] = {1'b0, 2'b10, 1'b0, 8'h10};
    for (int i = 0; i < n; i++) begin
      if (!(skip && img[i] == 16'hFFFF)) begin
        exp_ev[n_exp++] = {1'b0, 2'b00, 1'b0, 8'(i)};
        exp_ev[n_exp++] = {1'b0, 2'b01, 1'b0, img[i][7:0]};
        exp_ev[n_exp++] = {1'b0, 2'b01, 1'b1, img[i][15:8]};
        dirty = 1;
      end
      if (((i % 16) == 15 || i == n - 1) && dirty) begin
        if (!hv || hi != 8'(i >> 8)) begin
          exp_ev[n_exp++] = {1'b0, 2'b00, 1'b1, 8'(i >> 8)};
          hv = 1; hi = 8'(i >> 8);
        end
        exp_ev[n_exp++] = {1'b1, 2'b00, 1'b0, 8'h00};
        dirty = 0;
      end
    end
    if (with_nop) exp_ev[n_exp++] = {1'b0, 2'b10, 1'b0, 8'h00};
  endtask

  task automatic reset_dut(input bit skip);
    rst_n = 0; start = 0; s_valid = 0; s_last = 0; skip_erased = skip;
    repeat (3) @(negedge clk);
    chk({vcc_en, rst_lv_en, rst_hv_en, xtal1, s_ready, done, err, wr_n} == 8'b0000_0001,
        "R1", "reset outputs", {vcc_en, rst_lv_en, rst_hv_en, xtal1, s_ready, done, err, wr_n}, 1);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk({vcc_en, rst_hv_en, xtal1, s_ready, wr_n} == 5'b00001, "R1", "idle without start",
        {vcc_en, rst_hv_en, xtal1, s_ready, wr_n}, 1);
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic send(input int n, input bit mark_last);
    for (int i = 0; i < n; i++) begin
      int k = 0;
      repeat ($urandom_range(3, 0)) @(negedge clk);
      s_valid = 1; s_data = img[i]; s_last = mark_last && (i == n - 1);
      while (!s_ready && !err && !done && k < 20000) begin @(negedge clk); k++; end
      if (!s_ready) begin s_valid = 0; break; end
      @(negedge clk);
      s_valid = 0; s_last = 0;
    end
  endtask

  task automatic wait_end();
    int k = 0;
    while (!(done || err) && k < 60000) begin @(negedge clk); k++; end
    chk(done || err, "R9", "watchdog end of run", k, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_entry();
    chk(t_lv - t_vcc >= T60, "R2", "supply before reset", t_lv - t_vcc, T60);
    chk(t_hv - t_lv >= T20, "R2", "reset level before HV", t_hv - t_lv, T20);
    chk(t_str - t_hv >= T10, "R2", "HV before first strobe", t_str - t_hv, T10);
    chk(t_str - t_vcc < MS64, "R2", "entry within 64 ms", t_str - t_vcc, MS64);
    chk(ovl == 0, "R2", "reset level and HV overlap", ovl, 0);
  endtask

  task automatic compare_events(input string tag);
    chk(n_got == n_exp, "R7", {tag, " event count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      chk(got_ev[i] == exp_ev[i], req_of(exp_ev[i]), $sformatf("%s event %0d", tag, i),
          got_ev[i], exp_ev[i]);
    chk(setup_bad == 0, "R4", {tag, " strobe setup"}, setup_bad, 0);
    chk(busy_viol == 0, "R5", {tag, " activity while busy"}, busy_viol, 0);
    chk(rdy_viol == 0, "R11", {tag, " ready while not allowed"}, rdy_viol, 0);
  endtask

  task automatic run_ok(input int n, input bit skip, input string tag);
    int wrs = 0, ewrs = 0;
    lat_inf = 0;
    reset_dut(skip);
    send(n, 1);
    wait_end();
    gen_exp(n, skip, 1);
    check_entry();
    compare_events(tag);
    for (int i = 0; i < n_got && i < 4096; i++) wrs += got_ev[i][11];
    for (int i = 0; i < n_exp; i++) ewrs += exp_ev[i][11];
    chk(wrs == ewrs, "R8", {tag, " write pulse count"}, wrs, ewrs);
    chk(done && !err && !vcc_en && !rst_hv_en, "R9", {tag, " finished and powered down"},
        {done, err, vcc_en, rst_hv_en}, 4'b1000);
  endtask

  initial begin
    void'($urandom(32'd4242));

    for (int i = 0; i < 40; i++)
      img[i] = ($urandom_range(3, 0) == 0) ? 16'hFFFF : 16'($urandom());
    run_ok(40, 0, "unskipped");

    for (int i = 0; i < 300; i++)
      img[i] = ($urandom_range(3, 0) == 0) ? 16'hFFFF : 16'($urandom());
    for (int i = 32; i < 48; i++) img[i] = 16'hFFFF;
    for (int i = 240; i < 256; i++) img[i] = 16'hFFFF;
    img[15] = 16'hFFFF; img[14] = 16'h1234; img[271] = 16'hFFFF;
    run_ok(300, 1, "skipped");

    for (int i = 0; i < 5; i++) img[i] = 16'hFFFF;
    run_ok(5, 1, "all erased");

    img[0] = 16'hFFFF;
    run_ok(1, 0, "single word");

    for (int i = 0; i < 20; i++) img[i] = 16'($urandom());
    lat_inf = 1;
    reset_dut(0);
    send(20, 1);
    wait_end();
    gen_exp(16, 0, 0);
    compare_events("timeout");
    chk(err && !done, "R10", "error raised", {err, done}, 2'b10);
    chk(!vcc_en && !rst_hv_en && !s_ready, "R10", "powered down after error",
        {vcc_en, rst_hv_en, s_ready}, 0);
    chk(post_err == 0, "R10", "activity after error", post_err, 0);
    lat_inf = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule